// File: doc/BRIEF.md
# Downward-Growing Byte Stack Engine

This block is the stack pointer and stack access unit of a small 8-bit processor. The stack sits in byte-wide data SRAM and grows toward lower addresses. The pointer always names the next free byte. Four one-cycle command strobes drive the engine:

- a data byte push;
- a data byte pop;
- a two-byte return-address save, used on a call or on interrupt entry;
- a two-byte return-address restore, used on a subroutine or interrupt return.

The engine drives a single synchronous SRAM port. Writes complete at the clock edge. A read returns its data in the cycle after the address is presented.

Software sees the pointer as two byte-wide registers, low and high. Each one can be read and written on its own. A parameter removes the high register for parts with a small data space. In that case the pointer is one byte wide and wraps within that byte.

A guard flags any push or call made while the pointer sits in the reserved low region, at or below a limit. The limit defaults to 0x60. Both pointer bytes reset to 0x00, so software must load the pointer before it uses the stack.

Top module: `stack_engine`

## Requirements
- R1: An accepted push writes `push_data` to the address equal to the current pointer, in the same cycle. The pointer is one lower on the next cycle. `busy` stays low.
- R2: An accepted pop reads the address one above the pointer, and the pointer rises by one. `busy` is high for the next cycle. In the cycle after that, `pop_valid` is high for one cycle with the byte in `pop_data`.
- R3: An accepted call first writes `ret_addr_in[7:0]` at the current pointer. In the following cycle, with `busy` high, it writes `ret_addr_in[15:8]` one address lower. The pointer ends two lower. The return address is sampled only in the accept cycle.
- R4: An accepted return reads the byte above the pointer as the high half, then the next byte up as the low half. The pointer ends two higher. `busy` is high for two cycles. In the cycle after them, `ret_valid` pulses for one cycle with the 16-bit address on `ret_addr_out`.
- R5: Only one command is accepted per cycle. The priority is call, then return, then push, then pop. Every command that arrives while `busy` is high is ignored.
- R6: After reset, both pointer bytes read 0x00. Writing the low register leaves the high register unchanged, and writing the high register leaves the low register unchanged.
- R7: If a software pointer write arrives in the same cycle as an accepted stack command, the command's pointer update wins and the software write is dropped.
- R8: With `HAS_HIGH`=0, `sw_hi_rd` reads 0x00, writes to the high register have no effect, and the pointer wraps from 0x00 to 0xFF on a push.
- R9: `guard_err` pulses for one cycle after an accepted push or call whose starting pointer is at or below `GUARD_LIMIT` (0x60). It stays low after pops, returns, and pushes made from above the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push one data byte |
| cmd_pop | input | 1 | Pop one data byte |
| cmd_call | input | 1 | Save a two-byte return address |
| cmd_ret | input | 1 | Restore a two-byte return address |
| push_data | input | DATA_W | Byte to push |
| ret_addr_in | input | 2*DATA_W | Return address to save |
| pop_data | output | DATA_W | Popped byte |
| pop_valid | output | 1 | `pop_data` is valid this cycle |
| ret_addr_out | output | 2*DATA_W | Restored return address |
| ret_valid | output | 1 | `ret_addr_out` is valid this cycle |
| busy | output | 1 | Multi-cycle operation in progress |
| guard_err | output | 1 | Push or call made in the reserved low region |
| sw_wr_lo | input | 1 | Software write to the low pointer byte |
| sw_wr_hi | input | 1 | Software write to the high pointer byte |
| sw_wdata | input | DATA_W | Software write data |
| sw_lo_rd | output | DATA_W | Low pointer byte |
| sw_hi_rd | output | DATA_W | High pointer byte, zero when absent |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 2*DATA_W | SRAM byte address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after a read |

## Verification
Several properties are checked on every cycle:

- the pointer step for a push and for a pop;
- the address and data of the first write of a call;
- the one-address-lower second write of a call;
- the cycle on which pop and return results appear;
- the guard flag, in both directions.

Other behaviours can only be shown by the bench's scenarios against a memory model:

- that the bytes read back match the bytes written;
- command priority;
- that commands arriving during `busy` are dropped;
- that a stack command beats a software write;
- the absent high register and the one-byte wrap.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POP_W,
      ST_CALL2,
      ST_RET2,
      ST_RET3
   } stk_state_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_PUSH,
      OP_POP,
      OP_CALL,
      OP_RET
   } stk_op_e;

   // Fixed priority: call, return, push, pop
   function automatic stk_op_e pick_op(input logic c_call, input logic c_ret,
                                       input logic c_push, input logic c_pop);
      stk_op_e r;
      if (c_call)      r = OP_CALL;
      else if (c_ret)  r = OP_RET;
      else if (c_push) r = OP_PUSH;
      else if (c_pop)  r = OP_POP;
      else             r = OP_NONE;
      return r;
   endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          HAS_HIGH = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step_dn,
   input  logic                  step_up,
   input  logic                  sw_wr_lo,
   input  logic                  sw_wr_hi,
   input  logic [DATA_W-1:0]     sw_wdata,
   output logic [2*DATA_W-1:0]   ptr,
   output logic [2*DATA_W-1:0]   ptr_above
);
   localparam int unsigned PW = HAS_HIGH ? 2*DATA_W : DATA_W;
   localparam int unsigned AW = 2*DATA_W;
   localparam logic [PW-1:0] ONE = PW'(1);

   logic [PW-1:0] ptr_q, ptr_d, above_w;
   logic          hi_wr_en;

   generate
      if (HAS_HIGH) begin : g_hi_reg
         assign hi_wr_en  = sw_wr_hi;
         assign ptr       = ptr_q;
         assign ptr_above = above_w;
      end else begin : g_hi_none
         assign hi_wr_en  = 1'b0;
         assign ptr       = {{(AW-PW){1'b0}}, ptr_q};
         assign ptr_above = {{(AW-PW){1'b0}}, above_w};
      end
   endgenerate

   assign above_w = ptr_q + ONE;

   always_comb begin
      ptr_d = ptr_q;
      if (step_dn) begin
         ptr_d = ptr_q - ONE;
      end else if (step_up) begin
         ptr_d = above_w;
      end else begin
         if (sw_wr_lo) ptr_d[DATA_W-1:0]   = sw_wdata;
         if (hi_wr_en) ptr_d[PW-1 -: DATA_W] = sw_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

endmodule

// File: rtl/stk_guard.sv
module stk_guard #(
   parameter int unsigned AW          = 16,
   parameter int unsigned GUARD_LIMIT = 32'h60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chk_en,
   input  logic [AW-1:0] ptr,
   output logic          err
);
   localparam logic [AW-1:0] LIM = AW'(GUARD_LIMIT);

   logic in_low_zone;
   assign in_low_zone = (ptr <= LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else        err <= chk_en & in_low_zone;
   end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_push,
   input  logic                  cmd_pop,
   input  logic                  cmd_call,
   input  logic                  cmd_ret,
   input  logic [DATA_W-1:0]     push_data,
   input  logic [2*DATA_W-1:0]   ret_addr_in,
   input  logic [2*DATA_W-1:0]   ptr,
   input  logic [2*DATA_W-1:0]   ptr_above,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  step_dn,
   output logic                  step_up,
   output logic                  guard_chk,
   output logic                  busy,
   output logic                  mem_en,
   output logic                  mem_we,
   output logic [2*DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [DATA_W-1:0]     pop_data,
   output logic                  pop_valid,
   output logic [2*DATA_W-1:0]   ret_addr_out,
   output logic                  ret_valid
);
   stk_state_e          state_q, state_d;
   stk_op_e             op;
   logic [DATA_W-1:0]   call_hi_q;
   logic [DATA_W-1:0]   ret_hi_q;
   logic [DATA_W-1:0]   pop_q;
   logic                pop_v_q;
   logic [2*DATA_W-1:0] ret_q;
   logic                ret_v_q;

   assign busy = (state_q != ST_IDLE);
   assign op   = busy ? OP_NONE : pick_op(cmd_call, cmd_ret, cmd_push, cmd_pop);
   assign guard_chk = (op == OP_PUSH) || (op == OP_CALL);

   always_comb begin
      state_d   = state_q;
      step_dn   = 1'b0;
      step_up   = 1'b0;
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ptr;
      mem_wdata = '0;
      unique case (state_q)
         ST_IDLE: begin
            unique case (op)
               OP_PUSH: begin
                  mem_en = 1'b1; mem_we = 1'b1;
                  mem_wdata = push_data;
                  step_dn = 1'b1;
               end
               OP_POP: begin
                  mem_en = 1'b1; mem_addr = ptr_above;
                  step_up = 1'b1;
                  state_d = ST_POP_W;
               end
               OP_CALL: begin
                  mem_en = 1'b1; mem_we = 1'b1;
                  mem_wdata = ret_addr_in[DATA_W-1:0];
                  step_dn = 1'b1;
                  state_d = ST_CALL2;
               end
               OP_RET: begin
                  mem_en = 1'b1; mem_addr = ptr_above;
                  step_up = 1'b1;
                  state_d = ST_RET2;
               end
               default: ;
            endcase
         end
         ST_POP_W: state_d = ST_IDLE;
         ST_CALL2: begin
            mem_en = 1'b1; mem_we = 1'b1;
            mem_wdata = call_hi_q;
            step_dn = 1'b1;
            state_d = ST_IDLE;
         end
         ST_RET2: begin
            mem_en = 1'b1; mem_addr = ptr_above;
            step_up = 1'b1;
            state_d = ST_RET3;
         end
         ST_RET3: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         call_hi_q <= '0;
         ret_hi_q  <= '0;
         pop_q     <= '0;
         pop_v_q   <= 1'b0;
         ret_q     <= '0;
         ret_v_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         pop_v_q <= (state_q == ST_POP_W);
         ret_v_q <= (state_q == ST_RET3);
         if (op == OP_CALL)           call_hi_q <= ret_addr_in[2*DATA_W-1:DATA_W];
         if (state_q == ST_POP_W)     pop_q     <= mem_rdata;
         if (state_q == ST_RET2)      ret_hi_q  <= mem_rdata;
         if (state_q == ST_RET3)      ret_q     <= {ret_hi_q, mem_rdata};
      end
   end

   assign pop_data     = pop_q;
   assign pop_valid    = pop_v_q;
   assign ret_addr_out = ret_q;
   assign ret_valid    = ret_v_q;

endmodule

// File: rtl/stack_engine.sv
module stack_engine #(
   parameter int unsigned DATA_W      = 8,
   parameter bit          HAS_HIGH    = 1'b1,
   parameter int unsigned GUARD_LIMIT = 32'h60
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_push,
   input  logic                  cmd_pop,
   input  logic                  cmd_call,
   input  logic                  cmd_ret,
   input  logic [DATA_W-1:0]     push_data,
   input  logic [2*DATA_W-1:0]   ret_addr_in,
   output logic [DATA_W-1:0]     pop_data,
   output logic                  pop_valid,
   output logic [2*DATA_W-1:0]   ret_addr_out,
   output logic                  ret_valid,
   output logic                  busy,
   output logic                  guard_err,
   input  logic                  sw_wr_lo,
   input  logic                  sw_wr_hi,
   input  logic [DATA_W-1:0]     sw_wdata,
   output logic [DATA_W-1:0]     sw_lo_rd,
   output logic [DATA_W-1:0]     sw_hi_rd,
   output logic                  mem_en,
   output logic                  mem_we,
   output logic [2*DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic [DATA_W-1:0]     mem_rdata
);
   localparam int unsigned AW = 2*DATA_W;
   localparam int unsigned PW = HAS_HIGH ? AW : DATA_W;

   generate
      if (DATA_W < 4 || DATA_W > 16) begin : g_bad_width
         $error("stack_engine: DATA_W must lie in 4..16");
      end
      if (GUARD_LIMIT >= (64'd1 << PW)) begin : g_bad_limit
         $error("stack_engine: GUARD_LIMIT exceeds pointer range");
      end
   endgenerate

   logic [AW-1:0] ptr, ptr_above;
   logic          step_dn, step_up, guard_chk;

   stk_ptr #(.DATA_W(DATA_W), .HAS_HIGH(HAS_HIGH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_dn   (step_dn),
      .step_up   (step_up),
      .sw_wr_lo  (sw_wr_lo),
      .sw_wr_hi  (sw_wr_hi),
      .sw_wdata  (sw_wdata),
      .ptr       (ptr),
      .ptr_above (ptr_above)
   );

   stk_seq #(.DATA_W(DATA_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_push     (cmd_push),
      .cmd_pop      (cmd_pop),
      .cmd_call     (cmd_call),
      .cmd_ret      (cmd_ret),
      .push_data    (push_data),
      .ret_addr_in  (ret_addr_in),
      .ptr          (ptr),
      .ptr_above    (ptr_above),
      .mem_rdata    (mem_rdata),
      .step_dn      (step_dn),
      .step_up      (step_up),
      .guard_chk    (guard_chk),
      .busy         (busy),
      .mem_en       (mem_en),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .pop_data     (pop_data),
      .pop_valid    (pop_valid),
      .ret_addr_out (ret_addr_out),
      .ret_valid    (ret_valid)
   );

   stk_guard #(.AW(AW), .GUARD_LIMIT(GUARD_LIMIT)) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (guard_chk),
      .ptr    (ptr),
      .err    (guard_err)
   );

   assign sw_lo_rd = ptr[DATA_W-1:0];
   assign sw_hi_rd = ptr[AW-1:DATA_W];

endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk #(
   parameter int unsigned DATA_W      = 8,
   parameter bit          HAS_HIGH    = 1'b1,
   parameter int unsigned GUARD_LIMIT = 32'h60
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_push,
   input logic                  cmd_pop,
   input logic                  cmd_call,
   input logic                  cmd_ret,
   input logic [DATA_W-1:0]     push_data,
   input logic [2*DATA_W-1:0]   ret_addr_in,
   input logic [DATA_W-1:0]     pop_data,
   input logic                  pop_valid,
   input logic [2*DATA_W-1:0]   ret_addr_out,
   input logic                  ret_valid,
   input logic                  busy,
   input logic                  guard_err,
   input logic                  sw_wr_lo,
   input logic                  sw_wr_hi,
   input logic [DATA_W-1:0]     sw_wdata,
   input logic [DATA_W-1:0]     sw_lo_rd,
   input logic [DATA_W-1:0]     sw_hi_rd,
   input logic                  mem_en,
   input logic                  mem_we,
   input logic [2*DATA_W-1:0]   mem_addr,
   input logic [DATA_W-1:0]     mem_wdata,
   input logic [DATA_W-1:0]     mem_rdata
);
   localparam int unsigned AW = 2*DATA_W;
   localparam int unsigned PW = HAS_HIGH ? AW : DATA_W;
   localparam logic [AW-1:0] PMASK = AW'((64'd1 << PW) - 1);
   localparam logic [AW-1:0] ONE   = AW'(1);
   localparam logic [AW-1:0] LIM   = AW'(GUARD_LIMIT);

   logic [AW-1:0] sp;
   logic acc_push, acc_pop, acc_call, acc_ret;

   assign sp       = {sw_hi_rd, sw_lo_rd};
   assign acc_call = !busy && cmd_call;
   assign acc_ret  = !busy && !cmd_call && cmd_ret;
   assign acc_push = !busy && !cmd_call && !cmd_ret && cmd_push;
   assign acc_pop  = !busy && !cmd_call && !cmd_ret && !cmd_push && cmd_pop;

   a_r1_push_write: assert property (@(posedge clk) disable iff (!rst_n)
      acc_push |-> (mem_en && mem_we && mem_addr == sp && mem_wdata == push_data));

   a_r1_push_step: assert property (@(posedge clk) disable iff (!rst_n)
      acc_push |=> (((sp - $past(sp)) & PMASK) == PMASK) && !busy);

   a_r2_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      acc_pop |=> (((sp - $past(sp)) & PMASK) == ONE) && busy);

   a_r2_pop_result: assert property (@(posedge clk) disable iff (!rst_n)
      acc_pop |=> ##1 (pop_valid && !busy));

   a_r3_call_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      acc_call |-> (mem_we && mem_addr == sp && mem_wdata == ret_addr_in[DATA_W-1:0]));

   a_r3_call_high_next: assert property (@(posedge clk) disable iff (!rst_n)
      acc_call |=> (busy && mem_we &&
                    (((mem_addr - $past(mem_addr)) & PMASK) == PMASK)));

   a_r4_ret_result: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ret |=> busy ##1 busy ##1 (ret_valid && !busy));

   a_r5_single_result: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop_valid && ret_valid));

   a_r9_guard_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_push || acc_call) && sp <= LIM) |=> guard_err);

   a_r9_guard_cause: assert property (@(posedge clk) disable iff (!rst_n)
      guard_err |-> $past(!busy && (cmd_push || cmd_call)));

endmodule

bind stack_engine stack_engine_chk #(
   .DATA_W(DATA_W), .HAS_HIGH(HAS_HIGH), .GUARD_LIMIT(GUARD_LIMIT)
) u_chk (.*);

// File: tb/sim_stack_engine.sv
module sim_stack_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;

   // u0: full 16-bit pointer
   logic        cmd_push = 0, cmd_pop = 0, cmd_call = 0, cmd_ret = 0;
   logic [7:0]  push_data = 0;
   logic [15:0] ret_addr_in = 0;
   logic [7:0]  pop_data;
   logic        pop_valid;
   logic [15:0] ret_addr_out;
   logic        ret_valid, busy, guard_err;
   logic        sw_wr_lo = 0, sw_wr_hi = 0;
   logic [7:0]  sw_wdata = 0;
   logic [7:0]  sw_lo_rd, sw_hi_rd;
   logic        mem_en, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 0;
   logic [7:0]  mem0 [256];

   stack_engine u0 (
      .clk(clk), .rst_n(rst_n),
      .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
      .push_data(push_data), .ret_addr_in(ret_addr_in),
      .pop_data(pop_data), .pop_valid(pop_valid),
      .ret_addr_out(ret_addr_out), .ret_valid(ret_valid),
      .busy(busy), .guard_err(guard_err),
      .sw_wr_lo(sw_wr_lo), .sw_wr_hi(sw_wr_hi), .sw_wdata(sw_wdata),
      .sw_lo_rd(sw_lo_rd), .sw_hi_rd(sw_hi_rd),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem0[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= mem0[mem_addr[7:0]];
      end
   end

   // u1: no high pointer register
   logic        b_push = 0, b_wr_lo = 0, b_wr_hi = 0;
   logic [7:0]  b_wdata = 0;
   logic [7:0]  b_pop_data, b_lo, b_hi, b_mwdata;
   logic        b_pop_valid, b_ret_valid, b_busy, b_gerr, b_men, b_mwe;
   logic [15:0] b_ret_out, b_maddr;

   stack_engine #(.HAS_HIGH(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n),
      .cmd_push(b_push), .cmd_pop(1'b0), .cmd_call(1'b0), .cmd_ret(1'b0),
      .push_data(8'h5A), .ret_addr_in(16'h0000),
      .pop_data(b_pop_data), .pop_valid(b_pop_valid),
      .ret_addr_out(b_ret_out), .ret_valid(b_ret_valid),
      .busy(b_busy), .guard_err(b_gerr),
      .sw_wr_lo(b_wr_lo), .sw_wr_hi(b_wr_hi), .sw_wdata(b_wdata),
      .sw_lo_rd(b_lo), .sw_hi_rd(b_hi),
      .mem_en(b_men), .mem_we(b_mwe), .mem_addr(b_maddr),
      .mem_wdata(b_mwdata), .mem_rdata(8'h00)
   );

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sp();
      return {sw_hi_rd, sw_lo_rd};
   endfunction

   task automatic set_sp(input logic [15:0] v);
      sw_wr_hi = 1; sw_wdata = v[15:8];
      @(posedge clk); @(negedge clk);
      sw_wr_hi = 0; sw_wr_lo = 1; sw_wdata = v[7:0];
      @(posedge clk); @(negedge clk);
      sw_wr_lo = 0;
   endtask

   // One-edge command issue, starting and ending at a negedge
   task automatic issue(input logic p, input logic q, input logic c, input logic r);
      cmd_push = p; cmd_pop = q; cmd_call = c; cmd_ret = r;
      @(posedge clk); @(negedge clk);
      cmd_push = 0; cmd_pop = 0; cmd_call = 0; cmd_ret = 0;
   endtask

   task automatic do_pop(input logic [7:0] exp_d, input string req);
      issue(0, 1, 0, 0);
      check(busy == 1'b1, req, busy, 1);
      @(posedge clk); @(negedge clk);
      check(pop_valid && pop_data == exp_d, req, {pop_valid, pop_data}, {1'b1, exp_d});
      check(busy == 1'b0, req, busy, 0);
   endtask

   task automatic do_ret(input logic [15:0] exp_a, input string req);
      issue(0, 0, 0, 1);
      check(busy == 1'b1, req, busy, 1);
      @(posedge clk); @(negedge clk);
      check(busy == 1'b1 && !ret_valid, req, {busy, ret_valid}, 2'b10);
      @(posedge clk); @(negedge clk);
      check(ret_valid && ret_addr_out == exp_a, req, {ret_valid, ret_addr_out}, {1'b1, exp_a});
      @(posedge clk); @(negedge clk);
      check(ret_valid == 1'b0, req, ret_valid, 0);
   endtask

   task automatic t_reset();
      check(sp() == 16'h0000, "R6 reset pointer", sp(), 0);
      check(!busy && !pop_valid && !ret_valid && !guard_err, "R6 reset outputs",
            {busy, pop_valid, ret_valid, guard_err}, 0);
   endtask

   task automatic t_sw_regs();
      set_sp(16'h1234);
      check(sp() == 16'h1234, "R6 write both", sp(), 16'h1234);
      sw_wr_lo = 1; sw_wdata = 8'hAB;
      @(posedge clk); @(negedge clk);
      sw_wr_lo = 0;
      check(sp() == 16'h12AB, "R6 low leaves high", sp(), 16'h12AB);
      sw_wr_hi = 1; sw_wdata = 8'h00;
      @(posedge clk); @(negedge clk);
      sw_wr_hi = 0;
      check(sp() == 16'h00AB, "R6 high leaves low", sp(), 16'h00AB);
   endtask

   task automatic t_push_pop();
      set_sp(16'h00F0);
      push_data = 8'hA5;
      issue(1, 0, 0, 0);
      check(mem0[8'hF0] == 8'hA5, "R1 write at pointer", mem0[8'hF0], 8'hA5);
      check(sp() == 16'h00EF && !busy, "R1 pointer minus one", sp(), 16'h00EF);
      check(guard_err == 1'b0, "R9 no flag above limit", guard_err, 0);
      push_data = 8'h3C;
      issue(1, 0, 0, 0);
      check(mem0[8'hEF] == 8'h3C && sp() == 16'h00EE, "R1 second push", sp(), 16'h00EE);
      do_pop(8'h3C, "R2 pop last byte");
      check(sp() == 16'h00EF, "R2 pointer plus one", sp(), 16'h00EF);
      do_pop(8'hA5, "R2 pop first byte");
      check(sp() == 16'h00F0, "R2 pointer restored", sp(), 16'h00F0);
   endtask

   task automatic t_call_ret();
      mem0[8'hEE] = 8'h00;
      ret_addr_in = 16'hBEEF;
      issue(0, 0, 1, 0);
      check(busy == 1'b1, "R3 busy second cycle", busy, 1);
      ret_addr_in = 16'h0000;              // only accept cycle value matters
      cmd_push = 1; push_data = 8'h77;     // arrives while busy
      @(posedge clk); @(negedge clk);
      cmd_push = 0;
      check(mem0[8'hF0] == 8'hEF, "R3 low byte high address", mem0[8'hF0], 8'hEF);
      check(mem0[8'hEF] == 8'hBE, "R3 high byte below", mem0[8'hEF], 8'hBE);
      check(sp() == 16'h00EE, "R5 push during busy ignored ptr", sp(), 16'h00EE);
      check(mem0[8'hEE] == 8'h00, "R5 push during busy ignored mem", mem0[8'hEE], 0);
      do_ret(16'hBEEF, "R4 return address");
      check(sp() == 16'h00F0, "R4 pointer plus two", sp(), 16'h00F0);
   endtask

   task automatic t_priority();
      ret_addr_in = 16'h1234; push_data = 8'h99;
      issue(1, 0, 1, 0);
      @(posedge clk); @(negedge clk);
      check(sp() == 16'h00EE && mem0[8'hF0] == 8'h34, "R5 call beats push",
            sp(), 16'h00EE);
      issue(1, 0, 0, 1);
      check(busy == 1'b1, "R5 ret beats push", busy, 1);
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      check(ret_valid && ret_addr_out == 16'h1234 && sp() == 16'h00F0,
            "R5 ret beats push result", ret_addr_out, 16'h1234);
      push_data = 8'h42;
      issue(1, 1, 0, 0);
      check(sp() == 16'h00EF && mem0[8'hF0] == 8'h42 && !busy, "R5 push beats pop",
            sp(), 16'h00EF);
      do_pop(8'h42, "R5 cleanup pop");
   endtask

   task automatic t_sw_conflict();
      push_data = 8'h11;
      sw_wr_lo = 1; sw_wdata = 8'h20;
      issue(1, 0, 0, 0);
      sw_wr_lo = 0;
      check(sp() == 16'h00EF, "R7 stack update beats sw write", sp(), 16'h00EF);
      do_pop(8'h11, "R7 cleanup pop");
   endtask

   task automatic t_guard();
      set_sp(16'h0060);
      push_data = 8'h01;
      issue(1, 0, 0, 0);
      check(guard_err == 1'b1, "R9 push at limit flags", guard_err, 1);
      @(posedge clk); @(negedge clk);
      check(guard_err == 1'b0, "R9 flag is a pulse", guard_err, 0);
      do_pop(8'h01, "R9 pop from low zone");
      check(guard_err == 1'b0, "R9 pop never flags", guard_err, 0);
      set_sp(16'h0061);
      issue(1, 0, 0, 0);
      check(guard_err == 1'b0, "R9 push above limit", guard_err, 0);
      set_sp(16'h0060);
      ret_addr_in = 16'h0102;
      issue(0, 0, 1, 0);
      check(guard_err == 1'b1, "R9 call at limit flags", guard_err, 1);
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_no_high();
      b_wr_hi = 1; b_wdata = 8'h55;
      @(posedge clk); @(negedge clk);
      b_wr_hi = 0;
      check(b_hi == 8'h00, "R8 high write ignored", b_hi, 0);
      b_wr_lo = 1; b_wdata = 8'h00;
      @(posedge clk); @(negedge clk);
      b_wr_lo = 0;
      b_push = 1;
      @(posedge clk); @(negedge clk);
      b_push = 0;
      check(b_lo == 8'hFF && b_hi == 8'h00, "R8 one-byte wrap", {b_hi, b_lo}, 16'h00FF);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem0[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      t_reset();
      t_sw_regs();
      t_push_pop();
      t_call_ret();
      t_priority();
      t_sw_conflict();
      t_guard();
      t_no_high();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule